// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Model

This block is a synthesizable device-side model of a static RAM with independent read and write ports. Each port moves a burst of four 18-bit words across two clock cycles, one word per clock edge. One address bus carries a burst base address, and two active-low selects raise read and write requests. Address and selects are sampled on the rising edge of `clk`. The rising and falling edges of `clk` stand in for the true and complemented input and output clocks.

Write words arrive on four consecutive edges, starting with the rising edge one cycle after the request. They are stored under two active-low byte selects that are sampled on every beat. Read words leave on the same four-edge pattern, qualified by `q_oe`, which replaces a three-state pin. A request that follows an accepted request of the same kind on the very next rising edge is dropped. A read and a write may both be accepted on one edge. Because the address bus is shared, they then address the same burst, and the read returns the contents from before that write.

Top module: `qdr_sram`

## Requirements
- R1: While `rst_n` is low, and after it rises until a read is accepted, `q_oe` is 0, and no request is accepted during reset.
- R2: On a rising edge with both `rd_sel_n` and `wr_sel_n` high, nothing is accepted. `q_oe` is 0 in any half-cycle not covered by an accepted read.
- R3: A write accepted at rising edge t stores four words to word addresses {addr,00}, {addr,01}, {addr,10}, {addr,11}. The words are taken in that order from `d` at the rising edge of t+1, the falling edge of t+1, the rising edge of t+2 and the falling edge of t+2.
- R4: A read accepted at rising edge t drives the words of {addr,00}, {addr,01}, {addr,10}, {addr,11} in that order on `q`. Each word is driven in the high half of cycle t+1, the low half of t+1, the high half of t+2 and the low half of t+2, and `q_oe` is 1 in exactly those four half-cycles.
- R5: `bw_n[0]` low writes bits 8:0 and `bw_n[1]` low writes bits 17:9. A byte whose select is high keeps its previous contents.
- R6: The byte selects are taken separately with each of the four beats, so the beats of one burst may carry different masks.
- R7: A read request on the rising edge right after an accepted read is ignored. A read two edges after an accepted read is accepted, and its words follow the previous burst with no idle half-cycle between them.
- R8: A write request on the rising edge right after an accepted write is ignored, and data presented in its beat slots is not stored.
- R9: When a read and a write are accepted on the same edge, the read returns the burst as it stood before that write. A read accepted two or more edges after a write returns the written data.
- R10: A write accepted one edge after a read, to a different burst, does not disturb that read's output, and both complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge samples requests and even beats, falling edge odd beats |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request |
| wr_sel_n | input | 1 | Active-low write request |
| addr | input | ADDR_W-2 | Burst base address (word address without the two beat bits) |
| d | input | 18 | Write data beat |
| bw_n | input | 2 | Active-low byte write selects, bit 0 for bits 8:0, bit 1 for bits 17:9 |
| q | output | 18 | Read data beat (zero when `q_oe` is 0) |
| q_oe | output | 1 | Read data valid / output enable |

## Verification
A wrong acceptance state shows as a read burst that starts one cycle early or late, or as a missing burst. That error appears at `q_oe` within two cycles of the request edge. A misrouted write stage shows as a wrong word, or a byte that changes when it should not, but only when the burst is read back. The reference model therefore reads every written burst two or more edges later. A wrong beat order shows within the four half-cycles of a read, as words that appear swapped.

// File: rtl/qdr_pkg.sv
`timescale 1ns/1ps
package qdr_pkg;
  localparam int unsigned WORD_W     = 18;
  localparam int unsigned BYTE_W     = 9;
  localparam int unsigned NBYTES     = WORD_W / BYTE_W;
  localparam int unsigned BURST      = 4;
  localparam int unsigned BEAT_IDX_W = $clog2(BURST);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NBYTES-1:0] bmask_t;

  // Replace each byte whose active-low select is 0; keep the others.
  function automatic word_t byte_merge(word_t old_w, word_t new_w, bmask_t sel_n);
    word_t r;
    r = old_w;
    for (int b = 0; b < int'(NBYTES); b++)
      if (!sel_n[b]) r[b*BYTE_W +: BYTE_W] = new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/qdr_req_gate.sv
`timescale 1ns/1ps
// Accepts a request unless the same kind was accepted on the previous edge.
module qdr_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  output logic acc
);
  logic busy;

  assign acc = rst_n & ~sel_n & ~busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy <= 1'b0;
    else        busy <= acc;
endmodule

// File: rtl/qdr_write_path.sv
`timescale 1ns/1ps
// Captures the four write beats and turns them into two commit ports.
module qdr_write_path
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned BASE_W = ADDR_W - BEAT_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [BASE_W-1:0] base,
  input  word_t             d,
  input  bmask_t            bw_n,
  output logic              we0,
  output logic [ADDR_W-1:0] wa0,
  output word_t             wd0,
  output bmask_t            wm0,
  output logic              we1,
  output logic [ADDR_W-1:0] wa1,
  output word_t             wd1,
  output bmask_t            wm1
);
  logic              s1, s2, s3;
  logic [BASE_W-1:0] b1, b2, b3;
  word_t             nd;
  bmask_t            nbw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      b1 <= '0; b2 <= '0; b3 <= '0;
    end else begin
      s1 <= acc;  b1 <= base;
      s2 <= s1;   b2 <= b1;
      s3 <= s2;   b3 <= b2;
    end

  // Odd beats come on the falling edge.
  always_ff @(negedge clk) begin
    nd  <= d;
    nbw <= bw_n;
  end

  // Port 0: word 0 (stage 1) or word 1 (stage 2); port 1: word 2 (stage 2) or word 3 (stage 3).
  assign we0 = s1 | s2;
  assign wa0 = s1 ? {b1, BEAT_IDX_W'(0)} : {b2, BEAT_IDX_W'(1)};
  assign wd0 = s1 ? d    : nd;
  assign wm0 = s1 ? bw_n : nbw;

  assign we1 = s2 | s3;
  assign wa1 = s2 ? {b2, BEAT_IDX_W'(2)} : {b3, BEAT_IDX_W'(3)};
  assign wd1 = s2 ? d    : nd;
  assign wm1 = s2 ? bw_n : nbw;
endmodule

// File: rtl/qdr_array.sv
`timescale 1ns/1ps
// Word array: two byte-masked write ports, two asynchronous read ports.
module qdr_array
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we0,
  input  logic [ADDR_W-1:0] wa0,
  input  word_t             wd0,
  input  bmask_t            wm0,
  input  logic              we1,
  input  logic [ADDR_W-1:0] wa1,
  input  word_t             wd1,
  input  bmask_t            wm1,
  input  logic [ADDR_W-1:0] ra0,
  input  logic [ADDR_W-1:0] ra1,
  output word_t             rd0,
  output word_t             rd1
);
  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= byte_merge(mem[wa0], wd0, wm0);
    if (we1) mem[wa1] <= byte_merge(mem[wa1], wd1, wm1);
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/qdr_read_path.sv
`timescale 1ns/1ps
// Fetches two words per rising edge and drives them on both clock halves.
module qdr_read_path
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned BASE_W = ADDR_W - BEAT_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [BASE_W-1:0] base,
  output logic [ADDR_W-1:0] ra0,
  output logic [ADDR_W-1:0] ra1,
  input  word_t             rd0,
  input  word_t             rd1,
  output word_t             q,
  output logic              q_oe
);
  logic              s1, s2;
  logic [BASE_W-1:0] b1, b2;
  word_t             q_pos, q_nxt, q_neg;
  logic              oe_pos, oe_nxt, oe_neg;

  assign ra0 = s1 ? {b1, BEAT_IDX_W'(0)} : {b2, BEAT_IDX_W'(2)};
  assign ra1 = s1 ? {b1, BEAT_IDX_W'(1)} : {b2, BEAT_IDX_W'(3)};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; b1 <= '0; b2 <= '0;
      q_pos <= '0; q_nxt <= '0; oe_pos <= 1'b0; oe_nxt <= 1'b0;
    end else begin
      s1 <= acc; b1 <= base;
      s2 <= s1;  b2 <= b1;
      q_pos  <= rd0;
      q_nxt  <= rd1;
      oe_pos <= s1 | s2;
      oe_nxt <= s1 | s2;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      q_neg <= '0; oe_neg <= 1'b0;
    end else begin
      q_neg <= q_nxt; oe_neg <= oe_nxt;
    end

  assign q_oe = clk ? oe_pos : oe_neg;
  assign q    = q_oe ? (clk ? q_pos : q_neg) : '0;
endmodule

// File: rtl/qdr_sram.sv
`timescale 1ns/1ps
module qdr_sram
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned BASE_W = ADDR_W - BEAT_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [BASE_W-1:0] addr,
  input  logic [WORD_W-1:0] d,
  input  logic [NBYTES-1:0] bw_n,
  output logic [WORD_W-1:0] q,
  output logic              q_oe
);
  logic              rd_acc, wr_acc;
  logic              we0, we1;
  logic [ADDR_W-1:0] wa0, wa1, ra0, ra1;
  word_t             wd0, wd1, rd0, rd1;
  bmask_t            wm0, wm1;

  qdr_req_gate u_rd_gate (.clk(clk), .rst_n(rst_n), .sel_n(rd_sel_n), .acc(rd_acc));
  qdr_req_gate u_wr_gate (.clk(clk), .rst_n(rst_n), .sel_n(wr_sel_n), .acc(wr_acc));

  qdr_write_path #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .acc(wr_acc), .base(addr), .d(d), .bw_n(bw_n),
    .we0(we0), .wa0(wa0), .wd0(wd0), .wm0(wm0),
    .we1(we1), .wa1(wa1), .wd1(wd1), .wm1(wm1)
  );

  qdr_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk),
    .we0(we0), .wa0(wa0), .wd0(wd0), .wm0(wm0),
    .we1(we1), .wa1(wa1), .wd1(wd1), .wm1(wm1),
    .ra0(ra0), .ra1(ra1), .rd0(rd0), .rd1(rd1)
  );

  qdr_read_path #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .acc(rd_acc), .base(addr),
    .ra0(ra0), .ra1(ra1), .rd0(rd0), .rd1(rd1), .q(q), .q_oe(q_oe)
  );
endmodule

// File: rtl/qdr_sram_chk.sv
`timescale 1ns/1ps
module qdr_sram_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_sel_n,
  input logic              rd_acc,
  input logic              wr_acc,
  input logic              we0,
  input logic              we1,
  input logic [ADDR_W-1:0] wa0,
  input logic [ADDR_W-1:0] wa1,
  input logic              q_oe
);
  always_comb
    if (!rst_n) p_reset_idle_r1: assert (!q_oe);

  p_nop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_sel_n, 2) && $past(rd_sel_n, 3)) |-> !q_oe);

  p_commit_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && we1) |-> (wa0 != wa1));

  p_commit_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we0 |-> ($past(wr_acc) || $past(wr_acc, 2)));

  p_oe_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> ##1 q_oe);

  p_oe_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> ($past(rd_acc, 2) || $past(rd_acc, 3)));

  p_read_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);

  p_write_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_acc);
endmodule

bind qdr_sram qdr_sram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_qdr_sram.sv
`timescale 1ns/1ps
module test_qdr_sram;
  localparam int NC = 56;
  localparam int NS = 2*NC + 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [5:0]  addr = '0;
  logic [17:0] d = '0;
  logic [1:0]  bw_n = 2'b11;
  logic [17:0] q;
  logic        q_oe;

  qdr_sram i_qdr_sram (.clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
                       .addr(addr), .d(d), .bw_n(bw_n), .q(q), .q_oe(q_oe));

  always #5 clk = ~clk;

  // Stimulus schedule: per cycle and per half-cycle slot.
  logic        s_rps [NC];
  logic        s_wps [NC];
  logic [5:0]  s_addr[NC];
  string       s_rtag[NC];
  logic [17:0] s_d   [NS];
  logic [1:0]  s_bw  [NS];
  // Expected output per slot.
  logic        e_oe  [NS];
  logic [17:0] e_q   [NS];
  string       e_tag [NS];
  logic [17:0] mm    [256];

  int vectors = 0, fails = 0;
  bit done = 0;

  function automatic logic [17:0] val(int base, int k, int seed);
    return 18'((seed*977 + base*131 + k*17 + 5) ^ (seed << 9));
  endfunction

  task automatic put_write(int c, int base, int seed, logic [1:0] m0, logic [1:0] m1,
                           logic [1:0] m2, logic [1:0] m3);
    logic [1:0] m [4];
    m[0] = m0; m[1] = m1; m[2] = m2; m[3] = m3;
    s_wps[c] = 1'b0; s_addr[c] = 6'(base);
    for (int k = 0; k < 4; k++) begin
      s_d [2*c+2+k] = val(base, k, seed);
      s_bw[2*c+2+k] = m[k];
    end
  endtask

  task automatic put_read(int c, int base, string tag);
    s_rps[c] = 1'b0; s_addr[c] = 6'(base); s_rtag[c] = tag;
  endtask

  task automatic build;
    bit ra_p, wa_p, ra, wa;
    for (int c = 0; c < NC; c++) begin
      s_rps[c] = 1'b1; s_wps[c] = 1'b1; s_addr[c] = '0; s_rtag[c] = "R4";
    end
    for (int s = 0; s < NS; s++) begin
      s_d[s] = 18'(s * 4111); s_bw[s] = 2'b11;
      e_oe[s] = 1'b0; e_q[s] = '0; e_tag[s] = (s < 6) ? "R1" : "R2";
    end
    // R1: requests during reset are not accepted.
    s_rps[0] = 1'b0; s_addr[0] = 6'd1;
    s_wps[1] = 1'b0; s_addr[1] = 6'd2;
    // R3: full writes of bursts 1..5 (bw_n = 00 writes both bytes).
    for (int i = 0; i < 5; i++) put_write(3 + 2*i, 1 + i, 1, 2'b00, 2'b00, 2'b00, 2'b00);
    put_read(13, 1, "R3");
    // R7: back-to-back reads; c16 is ignored, c17 accepted with no gap.
    put_read(15, 2, "R7");
    put_read(16, 3, "R7");
    put_read(17, 3, "R7");
    // R5: burst 2 upper byte only (bw_n = 01); R6: burst 1 with a mask per beat.
    put_write(20, 2, 2, 2'b01, 2'b01, 2'b01, 2'b01);
    put_write(22, 1, 3, 2'b10, 2'b01, 2'b11, 2'b00);
    put_read(24, 2, "R5");
    put_read(26, 1, "R6");
    // R8: write at c29 right after c28 is ignored; its late beats must not land.
    put_write(28, 3, 4, 2'b00, 2'b00, 2'b00, 2'b00);
    s_wps[29] = 1'b0; s_addr[29] = 6'd4;
    s_d[62] = 18'h3ffff; s_bw[62] = 2'b00;
    s_d[63] = 18'h2aaaa; s_bw[63] = 2'b00;
    put_read(31, 4, "R8");
    put_read(33, 3, "R3");
    // R9: read and write on one edge to burst 5, then read it again.
    put_write(36, 5, 5, 2'b00, 2'b00, 2'b00, 2'b00);
    put_read(36, 5, "R9");
    put_read(38, 5, "R9");
    // R10: write one edge after a read, to another burst.
    put_read(41, 1, "R10");
    put_write(42, 6, 6, 2'b00, 2'b00, 2'b00, 2'b00);
    put_read(45, 6, "R10");
    put_write(46, 7, 7, 2'b00, 2'b00, 2'b00, 2'b00);
    put_read(47, 2, "R10");
    put_read(49, 7, "R10");

    // Behavioural reference: reads see earlier writes, not the same-edge one.
    ra_p = 0; wa_p = 0;
    for (int c = 0; c < NC; c++) begin
      ra = (c >= 2) && !s_rps[c] && !ra_p;
      wa = (c >= 2) && !s_wps[c] && !wa_p;
      if (ra)
        for (int k = 0; k < 4; k++) begin
          e_oe [2*c+2+k] = 1'b1;
          e_q  [2*c+2+k] = mm[int'(s_addr[c])*4 + k];
          e_tag[2*c+2+k] = s_rtag[c];
        end
      if (wa)
        for (int k = 0; k < 4; k++) begin
          int w = int'(s_addr[c])*4 + k;
          logic [17:0] nv = s_d[2*c+2+k];
          logic [1:0]  m  = s_bw[2*c+2+k];
          mm[w] = { m[1] ? mm[w][17:9] : nv[17:9], m[0] ? mm[w][8:0] : nv[8:0] };
        end
      ra_p = ra; wa_p = wa;
    end
  endtask

  // Driver: even beat / request before the rising edge, odd beat before the falling edge.
  initial begin
    build();
    #2;
    for (int c = 0; c < NC + 8; c++) begin
      if (c < NC) begin
        rd_sel_n = s_rps[c]; wr_sel_n = s_wps[c]; addr = s_addr[c];
      end else begin
        rd_sel_n = 1'b1; wr_sel_n = 1'b1;
      end
      d = s_d[2*c]; bw_n = s_bw[2*c];
      if (c == 2) rst_n = 1'b1;
      #5;
      d = s_d[2*c+1]; bw_n = s_bw[2*c+1];
      #5;
    end
  end

  // Checker: one vector per half-cycle, sampled mid-phase.
  initial begin
    #1;
    vectors++;
    if (q_oe !== 1'b0) begin
      fails++;
      $display("FAIL R1 at power-up: q_oe=%b expected 0", q_oe);
    end
    #7;
    for (int s = 0; s < NS; s++) begin
      vectors++;
      if (e_oe[s]) begin
        if (q_oe !== 1'b1 || q !== e_q[s]) begin
          fails++;
          $display("FAIL %s slot %0d: q_oe=%b q=%h expected q_oe=1 q=%h", e_tag[s], s, q_oe, q, e_q[s]);
        end
      end else if (q_oe !== 1'b0) begin
        fails++;
        $display("FAIL %s slot %0d: q_oe=%b expected 0", e_tag[s], s, q_oe);
      end
      #5;
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule